// File: doc/BRIEF.md
# Two-Channel PWM Action Qualifier

This block is the output stage that turns a time-base counter into two PWM waveforms, A and B. On every time-base tick it looks at the events of that tick: counter at zero, counter at period, and an upward-counting match of the counter against either of two compare registers. It then applies a 2-bit action to each output: none, clear, set or toggle. Each output has its own action register, with one field for each event. Outputs change only on ticks.

A software-force field per channel can hold an output low or high regardless of the counter. Software writes a shadow copy of the force fields. A reload mode decides when the shadow reaches the active copy: at zero, at period, at either event, or on the next tick. This lets software switch an output off cleanly at a period boundary or at once.

Software programs normal polarity by writing actions that set the output at zero and at period and clear it at the compare match. Inverted polarity uses the opposite actions. Register writes use a simple write strobe with an address and 16 bits of data.

Top module: `pwm_action_qual`

## Requirements
- R1: After a synchronous active-low reset, both outputs are low. Every register reads as zero, which gives compare values 0, all actions "none", both forces disabled and reload mode "at zero". Ticks carrying zero and period events therefore leave both outputs low.
- R2: Outputs change only on a clock edge where `tick` is high. A register write made without a tick leaves both outputs unchanged.
- R3: An action code of 2'b00 leaves the output unchanged, 2'b01 drives it low, 2'b10 drives it high and 2'b11 inverts it.
- R4: The write addresses are: 0 compare A, 1 compare B, 2 channel A actions, 3 channel B actions, 4 force levels, 5 reload mode. In each action register, bits 1:0 hold the zero action, bits 3:2 the period action, bits 5:4 the compare-A-up action and bits 9:8 the compare-B-up action.
- R5: A compare event fires only on a tick where `cnt` equals that compare register and `dir_up` is high. An equal count while counting down has no effect.
- R6: When several events occur on one tick, the event with the highest priority and a non-"none" action decides the output. The order from highest to lowest is period, compare B, compare A, zero.
- R7: Force levels are written at address 4, channel A in bits 1:0 and channel B in bits 3:2. A value of 01 forces the output low and 10 forces it high, overriding all events. A value of 00 or 11 disables the force.
- R8: The reload mode is written at address 5, bits 1:0. The written force levels become active on a tick with a zero event (00), with a period event (01), with either event (10), or on the next tick of any kind (11). They take effect on that same tick.
- R9: With normal polarity (set on zero and period, clear on compare up) or with inverted polarity, an up-counting period produces the expected pulse. Normal polarity gives a high output from zero to the compare match. Inverted polarity gives a low output over the same span.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Time-base tick; outputs update only on these cycles |
| cnt | input | 16 | Time-base counter value |
| dir_up | input | 1 | High while the counter counts upward |
| zero_evt | input | 1 | Counter-at-zero event strobe |
| prd_evt | input | 1 | Counter-at-period event strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| pwm_a | output | 1 | PWM output A |
| pwm_b | output | 1 | PWM output B |

## Verification
On every cycle the assertions check the following. The outputs come out of reset low and hold steady between ticks. An active forced level reaches its output on the tick. A down-counting tick with no zero or period event leaves output A alone. A programmed period action wins whatever the other events do. The bench scenarios cover what a single-cycle property cannot express: whole polarity waveforms, the order among coinciding events, toggling, the placement of each field, and a shadowed force level waiting until its reload event arrives in each reload mode.

// File: rtl/aq_pkg.sv
// Package: shared types and constants for the PWM action qualifier.
// Assumes two outputs and 2-bit codes throughout.
package aq_pkg;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'b00,
        ACT_LOW    = 2'b01,
        ACT_HIGH   = 2'b10,
        ACT_TOGGLE = 2'b11
    } aq_act_e;

    typedef enum logic [1:0] {
        FRC_OFF  = 2'b00,
        FRC_LOW  = 2'b01,
        FRC_HIGH = 2'b10,
        FRC_OFF2 = 2'b11
    } aq_frc_e;

    typedef enum logic [1:0] {
        RLD_ZERO   = 2'b00,
        RLD_PRD    = 2'b01,
        RLD_EITHER = 2'b10,
        RLD_NOW    = 2'b11
    } aq_rld_e;

    // Events qualified by tick
    typedef struct packed {
        logic zero;
        logic prd;
        logic cmpa_up;
        logic cmpb_up;
    } aq_evt_t;

    localparam int ACT_W        = 10;
    localparam int FLD_ZERO_LSB = 0;
    localparam int FLD_PRD_LSB  = 2;
    localparam int FLD_CAU_LSB  = 4;
    localparam int FLD_CBU_LSB  = 8;

    localparam int ADR_CMPA  = 0;
    localparam int ADR_CMPB  = 1;
    localparam int ADR_ACT0  = 2;
    localparam int ADR_FORCE = 4;
    localparam int ADR_RLD   = 5;

    // Result of applying an action code to the current level
    function automatic logic aq_apply(input aq_act_e code, input logic cur);
        case (code)
            ACT_LOW:    return 1'b0;
            ACT_HIGH:   return 1'b1;
            ACT_TOGGLE: return ~cur;
            default:    return cur;
        endcase
    endfunction

endpackage

// File: rtl/aq_regs.sv
// Module: register file of the action qualifier.
// Holds the compare values, per-channel action words, the force shadow,
// the active force and the reload mode. Produces the force level that
// applies on the current tick. Assumes DATA_W >= CNT_W and >= ACT_W.
module aq_regs
    import aq_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 3,
    parameter int DATA_W = 16,
    parameter int NUM_CH = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [ADDR_W-1:0]                 wr_addr,
    input  logic [DATA_W-1:0]                 wr_data,
    input  logic                              tick,
    input  logic                              zero_q,
    input  logic                              prd_q,
    output logic [CNT_W-1:0]                  cmp_a,
    output logic [CNT_W-1:0]                  cmp_b,
    output logic [NUM_CH-1:0][ACT_W-1:0]      act_cfg,
    output logic [NUM_CH-1:0][1:0]            frc_eff
);

    localparam int FRC_W = 2 * NUM_CH;

    logic [FRC_W-1:0] frc_shd_q;
    logic [FRC_W-1:0] frc_act_q;
    aq_rld_e          rld_q;
    logic             load_now;

    // Software writes into the configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_a     <= '0;
            cmp_b     <= '0;
            act_cfg   <= '0;
            frc_shd_q <= '0;
            rld_q     <= RLD_ZERO;
        end else if (wr_en) begin
            if (wr_addr == ADDR_W'(ADR_CMPA))  cmp_a     <= wr_data[CNT_W-1:0];
            if (wr_addr == ADDR_W'(ADR_CMPB))  cmp_b     <= wr_data[CNT_W-1:0];
            if (wr_addr == ADDR_W'(ADR_FORCE)) frc_shd_q <= wr_data[FRC_W-1:0];
            if (wr_addr == ADDR_W'(ADR_RLD))   rld_q     <= aq_rld_e'(wr_data[1:0]);
            for (int ch = 0; ch < NUM_CH; ch++) begin
                if (wr_addr == ADDR_W'(ADR_ACT0 + ch))
                    act_cfg[ch] <= wr_data[ACT_W-1:0];
            end
        end
    end

    // Decide whether the shadow force reaches the active copy this tick
    always_comb begin
        case (rld_q)
            RLD_ZERO:   load_now = tick & zero_q;
            RLD_PRD:    load_now = tick & prd_q;
            RLD_EITHER: load_now = tick & (zero_q | prd_q);
            default:    load_now = tick;
        endcase
    end

    // Active force copy, refreshed from the shadow on a reload tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frc_act_q <= '0;
        end else if (load_now) begin
            frc_act_q <= frc_shd_q;
        end
    end

    // Force level in effect on this cycle, per channel
    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_frc
            assign frc_eff[g] = load_now ? frc_shd_q[2*g +: 2] : frc_act_q[2*g +: 2];
        end
    endgenerate

endmodule

// File: rtl/aq_event_decode.sv
// Module: qualifies the time-base strobes with tick and detects
// upward compare matches against both compare registers.
// Assumes the strobes and counter are valid whenever tick is high.
module aq_event_decode
    import aq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             tick,
    input  logic [CNT_W-1:0] cnt,
    input  logic             dir_up,
    input  logic             zero_evt,
    input  logic             prd_evt,
    input  logic [CNT_W-1:0] cmp_a,
    input  logic [CNT_W-1:0] cmp_b,
    output aq_evt_t          evt
);

    // Event vector valid only on a tick
    always_comb begin
        evt.zero    = tick & zero_evt;
        evt.prd     = tick & prd_evt;
        evt.cmpa_up = tick & dir_up & (cnt == cmp_a);
        evt.cmpb_up = tick & dir_up & (cnt == cmp_b);
    end

endmodule

// File: rtl/aq_channel.sv
// Module: one output of the action qualifier. Picks the action of the
// highest-priority event whose code is not "none" (period, compare B,
// compare A, zero), lets an active force override it, and registers
// the result on a tick. Assumes evt is already gated by tick.
module aq_channel
    import aq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  aq_evt_t          evt,
    input  logic [ACT_W-1:0] act,
    input  logic [1:0]       frc,
    output logic             pwm
);

    aq_act_e code;
    logic    nxt;

    // Priority selection: later statements override earlier ones
    always_comb begin
        code = ACT_NONE;
        if (evt.zero && act[FLD_ZERO_LSB +: 2] != 2'b00)
            code = aq_act_e'(act[FLD_ZERO_LSB +: 2]);
        if (evt.cmpa_up && act[FLD_CAU_LSB +: 2] != 2'b00)
            code = aq_act_e'(act[FLD_CAU_LSB +: 2]);
        if (evt.cmpb_up && act[FLD_CBU_LSB +: 2] != 2'b00)
            code = aq_act_e'(act[FLD_CBU_LSB +: 2]);
        if (evt.prd && act[FLD_PRD_LSB +: 2] != 2'b00)
            code = aq_act_e'(act[FLD_PRD_LSB +: 2]);
    end

    // Next level: force overrides the event action
    always_comb begin
        case (aq_frc_e'(frc))
            FRC_LOW:  nxt = 1'b0;
            FRC_HIGH: nxt = 1'b1;
            default:  nxt = aq_apply(code, pwm);
        endcase
    end

    // Output register, updated on ticks only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwm <= 1'b0;
        end else if (tick) begin
            pwm <= nxt;
        end
    end

endmodule

// File: rtl/pwm_action_qual.sv
// Module: two-channel PWM action qualifier top. Connects the register
// file, the event decoder and one output stage per channel.
// Assumes a free-running external time base supplies cnt, dir_up,
// zero_evt, prd_evt and tick.
module pwm_action_qual
    import aq_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 3,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              dir_up,
    input  logic              zero_evt,
    input  logic              prd_evt,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              pwm_a,
    output logic              pwm_b
);

    localparam int NUM_CH = 2;

    logic [CNT_W-1:0]                 cmp_a;
    logic [CNT_W-1:0]                 cmp_b;
    logic [NUM_CH-1:0][ACT_W-1:0]     act_cfg;
    logic [NUM_CH-1:0][1:0]           frc_eff;
    logic [NUM_CH-1:0]                pwm_vec;
    aq_evt_t                          evt;

    aq_regs #(
        .CNT_W  (CNT_W),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .NUM_CH (NUM_CH)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .tick    (tick),
        .zero_q  (evt.zero),
        .prd_q   (evt.prd),
        .cmp_a   (cmp_a),
        .cmp_b   (cmp_b),
        .act_cfg (act_cfg),
        .frc_eff (frc_eff)
    );

    aq_event_decode #(
        .CNT_W (CNT_W)
    ) u_dec (
        .tick     (tick),
        .cnt      (cnt),
        .dir_up   (dir_up),
        .zero_evt (zero_evt),
        .prd_evt  (prd_evt),
        .cmp_a    (cmp_a),
        .cmp_b    (cmp_b),
        .evt      (evt)
    );

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
            aq_channel u_ch (
                .clk   (clk),
                .rst_n (rst_n),
                .tick  (tick),
                .evt   (evt),
                .act   (act_cfg[g]),
                .frc   (frc_eff[g]),
                .pwm   (pwm_vec[g])
            );
        end
    endgenerate

    assign pwm_a = pwm_vec[0];
    assign pwm_b = pwm_vec[1];

endmodule

// File: rtl/pwm_action_qual_checker.sv
// Module: assertion checker bound into the action qualifier top.
// Assumes two channels and the field layout in aq_pkg.
module pwm_action_qual_checker
    import aq_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 tick,
    input logic                 dir_up,
    input logic                 zero_evt,
    input logic                 prd_evt,
    input logic [1:0][1:0]      frc_eff,
    input logic [1:0][ACT_W-1:0] act_cfg,
    input logic                 pwm_a,
    input logic                 pwm_b
);

    a_r1_reset_low: assert property (@(posedge clk)
        !rst_n |=> (!pwm_a && !pwm_b));

    a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(pwm_a) && $stable(pwm_b)));

    a_r7_force_low_a: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && frc_eff[0] == FRC_LOW) |=> !pwm_a);

    a_r7_force_high_b: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && frc_eff[1] == FRC_HIGH) |=> pwm_b);

    a_r5_down_count_no_match: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !dir_up && !zero_evt && !prd_evt &&
         frc_eff[0] != FRC_LOW && frc_eff[0] != FRC_HIGH) |=> $stable(pwm_a));

    a_r6_period_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && prd_evt && frc_eff[0] != FRC_LOW && frc_eff[0] != FRC_HIGH &&
         act_cfg[0][FLD_PRD_LSB +: 2] == ACT_HIGH) |=> pwm_a);

endmodule

bind pwm_action_qual pwm_action_qual_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .dir_up   (dir_up),
    .zero_evt (zero_evt),
    .prd_evt  (prd_evt),
    .frc_eff  (frc_eff),
    .act_cfg  (act_cfg),
    .pwm_a    (pwm_a),
    .pwm_b    (pwm_b)
);

// File: tb/pwm_action_qual_bench.sv
`timescale 1ns/1ps
// Bench: scoreboard style. Driver tasks apply one cycle of stimulus,
// update a requirement-level model and queue the expected outputs;
// a monitor pops one entry per cycle just after the edge and compares.
module pwm_action_qual_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [15:0] cnt = '0;
    logic        dir_up = 1'b1;
    logic        zero_evt = 1'b0;
    logic        prd_evt = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        pwm_a;
    logic        pwm_b;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [1:0] exp_q[$];
    string      tag_q[$];

    // Model state
    logic [15:0] m_cmpa = '0, m_cmpb = '0;
    logic [9:0]  m_act[2] = '{10'h0, 10'h0};
    logic [3:0]  m_fshd = '0, m_fact = '0;
    logic [1:0]  m_rld = '0;
    logic        m_out[2] = '{1'b0, 1'b0};

    always #2.5 clk = ~clk;

    pwm_action_qual u_pwm_action_qual (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(cnt), .dir_up(dir_up),
        .zero_evt(zero_evt), .prd_evt(prd_evt), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .pwm_a(pwm_a), .pwm_b(pwm_b)
    );

    function automatic logic apply_code(input logic [1:0] c, input logic cur);
        if (c == 2'b01) return 1'b0;
        if (c == 2'b10) return 1'b1;
        if (c == 2'b11) return ~cur;
        return cur;
    endfunction

    task automatic push(input string tag);
        exp_q.push_back({m_out[1], m_out[0]});
        tag_q.push_back(tag);
    endtask

    task automatic idle(input string tag);
        @(negedge clk);
        tick = 0; wr_en = 0; zero_evt = 0; prd_evt = 0;
        push(tag);
    endtask

    task automatic wr(input int addr, input logic [15:0] data, input string tag);
        @(negedge clk);
        tick = 0; zero_evt = 0; prd_evt = 0;
        wr_en = 1; wr_addr = 3'(addr); wr_data = data;
        case (addr)
            0: m_cmpa = data;
            1: m_cmpb = data;
            2: m_act[0] = data[9:0];
            3: m_act[1] = data[9:0];
            4: m_fshd = data[3:0];
            5: m_rld = data[1:0];
            default: ;
        endcase
        push(tag);
    endtask

    task automatic tk(input int c, input logic up, input logic z, input logic p,
                      input string tag);
        logic ld;
        logic [1:0] f, code;
        @(negedge clk);
        wr_en = 0; tick = 1; cnt = 16'(c); dir_up = up; zero_evt = z; prd_evt = p;
        case (m_rld)
            2'b00: ld = z;
            2'b01: ld = p;
            2'b10: ld = z | p;
            default: ld = 1'b1;
        endcase
        if (ld) m_fact = m_fshd;
        for (int ch = 0; ch < 2; ch++) begin
            f = m_fact[2*ch +: 2];
            code = 2'b00;
            if (z && m_act[ch][1:0] != 0) code = m_act[ch][1:0];
            if (up && 16'(c) == m_cmpa && m_act[ch][5:4] != 0) code = m_act[ch][5:4];
            if (up && 16'(c) == m_cmpb && m_act[ch][9:8] != 0) code = m_act[ch][9:8];
            if (p && m_act[ch][3:2] != 0) code = m_act[ch][3:2];
            if (f == 2'b01)      m_out[ch] = 1'b0;
            else if (f == 2'b10) m_out[ch] = 1'b1;
            else                 m_out[ch] = apply_code(code, m_out[ch]);
        end
        push(tag);
    endtask

    // One up-counting period from 0 to prd
    task automatic period_run(input int prd, input string tag);
        for (int i = 0; i <= prd; i++) tk(i, 1'b1, i == 0, i == prd, tag);
    endtask

    // Monitor: compare one queued expectation per cycle
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if ({pwm_b, pwm_a} !== e) begin
                    failures++;
                    $display("FAIL %s: got b,a=%b%b expected %b%b", t, pwm_b, pwm_a, e[1], e[0]);
                end
            end
        end
    end

    // Watchdog
    initial begin
        #(200000 * 5);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        idle("R1 reset outputs low");
        tk(0, 1'b1, 1'b1, 1'b0, "R1 no action after reset");
        tk(7, 1'b1, 1'b0, 1'b1, "R1 no action after reset");
        tk(0, 1'b1, 1'b0, 1'b0, "R1 compare zero default none");

        // Normal polarity on A, inverted on B
        wr(0, 16'd3, "R2 write no change");
        wr(1, 16'd5, "R2 write no change");
        wr(2, 16'h001A, "R2 write no change");
        wr(3, 16'h0205, "R2 write no change");
        period_run(8, "R9 polarity period 1");
        period_run(8, "R9 polarity period 2");
        wr(0, 16'd6, "R2 write no change");
        idle("R2 idle hold");
        period_run(8, "R9 new compare");

        // Toggle code on zero field
        wr(2, 16'h0003, "R3 toggle setup");
        wr(3, 16'h0001, "R3 low setup");
        tk(0, 1'b1, 1'b1, 1'b0, "R3 toggle first");
        tk(0, 1'b1, 1'b1, 1'b0, "R3 toggle second");
        tk(0, 1'b1, 1'b1, 1'b0, "R3 toggle third");

        // Compare-B field in channel A register
        wr(2, 16'h0200, "R4 cbu in A");
        wr(1, 16'd5, "R4 cmpb");
        tk(5, 1'b1, 1'b0, 1'b0, "R4 compare B up acts on A");
        wr(2, 16'h0100, "R4 cbu clear");
        tk(5, 1'b0, 1'b0, 1'b0, "R5 down count ignored");
        tk(5, 1'b1, 1'b0, 1'b0, "R5 up count matches");

        // Priority cases
        wr(2, 16'h0009, "R6 setup");
        tk(0, 1'b1, 1'b1, 1'b1, "R6 period over zero");
        wr(2, 16'h0012, "R6 setup");
        wr(0, 16'd0, "R6 setup");
        tk(0, 1'b1, 1'b1, 1'b0, "R6 compare over zero");
        wr(2, 16'h0120, "R6 setup");
        wr(0, 16'd4, "R6 setup");
        wr(1, 16'd6, "R6 setup");
        tk(4, 1'b1, 1'b0, 1'b0, "R5 compare A alone");
        wr(1, 16'd4, "R6 setup");
        tk(4, 1'b1, 1'b0, 1'b0, "R6 compare B over compare A");
        wr(2, 16'h001A, "R6 setup");
        wr(0, 16'd8, "R6 setup");
        tk(8, 1'b1, 1'b0, 1'b1, "R6 period over compare");
        tk(4, 1'b0, 1'b0, 1'b0, "R5 down at compare B value ignored");

        // Force with reload at zero
        wr(0, 16'd3, "R8 setup");
        wr(1, 16'd5, "R8 setup");
        wr(3, 16'h010A, "R8 setup");
        wr(4, 16'h0001, "R7 force A low shadow");
        tk(1, 1'b1, 1'b0, 1'b0, "R8 zero mode waits");
        tk(8, 1'b1, 1'b0, 1'b1, "R8 zero mode ignores period");
        tk(0, 1'b1, 1'b1, 1'b0, "R8 zero mode loads");
        period_run(8, "R7 A held low");
        // Reload at period
        wr(5, 16'h0001, "R8 mode period");
        wr(4, 16'h0008, "R7 force B high shadow");
        tk(0, 1'b1, 1'b1, 1'b0, "R8 period mode ignores zero");
        tk(5, 1'b1, 1'b0, 1'b0, "R8 period mode waits");
        tk(8, 1'b1, 1'b0, 1'b1, "R8 period mode loads");
        tk(5, 1'b1, 1'b0, 1'b0, "R7 B held high over compare");
        // Reload at either event
        wr(5, 16'h0002, "R8 mode either");
        wr(4, 16'h0004, "R7 force B low shadow");
        tk(2, 1'b1, 1'b0, 1'b0, "R8 either waits");
        tk(0, 1'b1, 1'b1, 1'b0, "R8 either loads on zero");
        wr(4, 16'h000F, "R7 code 11 disables");
        tk(8, 1'b1, 1'b0, 1'b1, "R8 either loads on period");
        // Immediate reload
        wr(5, 16'h0003, "R8 mode now");
        wr(4, 16'h0002, "R7 force A high shadow");
        idle("R2 no tick no load");
        tk(2, 1'b1, 1'b0, 1'b0, "R8 now applies on next tick");
        tk(3, 1'b1, 1'b0, 1'b0, "R7 A held high over compare");
        wr(4, 16'h0000, "R7 release");
        tk(3, 1'b1, 1'b0, 1'b0, "R8 release applies");
        period_run(8, "R9 after release");
        idle("R2 final idle");

        wait (exp_q.size() == 0);
        @(posedge clk);
        #2;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule